// File: doc/BRIEF.md
# Renaming Reservation Station Pool

This block holds the waiting operations of one functional unit class. Each issued operation names two source registers and a destination register. At issue every source is resolved against a register alias table. If no operation in flight will write that register, its current value is copied into the station. Otherwise the station stores the tag of the producing station and waits. The destination register is then renamed to the tag of the new station, so older readers and older writers of the same register no longer constrain it.

A shared result bus carries a tag and a data word. Waiting stations compare the tag with their pending sources and take the data on a match. The register file takes the data only when the register is still renamed to that tag. When both operands of a station are present it competes for the execution unit, and the oldest ready station wins. The execution unit is a stub with a fixed latency, pipelined so that it accepts one operation per cycle. Its output drives the result bus, and the station is released in the cycle that its result appears there.

A read port shows the value of any register and whether a rename is pending on it. The bench uses it to observe the architectural state.

Top module: `rs_pool`

## Requirements
- R1: After reset, issue_ready_o is 1, cdb_valid_o is 0, no register has a rename pending, and register i holds (17*i + 5) modulo 2^DATA_W.
- R2: An operation is accepted in a cycle where issue_valid_i and issue_ready_o are both 1. It takes the lowest-numbered free station, and that station number is shown on issue_tag_o during the accepting cycle. issue_ready_o is 0 while every station is busy, and an offered operation then waits.
- R3: The result is the operation applied to a = value of rs1 and b = value of rs2, truncated to DATA_W, where the register values are those that in-order execution would see. The op codes are 0 = a+b, 1 = a-b, 2 = a&b, 3 = a^b.
- R4: From the edge that accepts an operation, its destination register reads as pending until a broadcast carries the tag that the register was last renamed to.
- R5: A station waiting on a source takes the bus data when the broadcast tag equals the stored producer tag. Chains of dependent operations therefore produce the in-order results.
- R6: A station executes only once both operands are present. An operation whose operands are available at issue, with no competitor, appears on the result bus after exactly EXEC_LAT clock edges following its accepting edge. No operation appears earlier than that.
- R7: Every accepted operation is broadcast exactly once, with its station tag and its result. The station becomes free at the edge that ends the broadcast cycle.
- R8: A broadcast writes a register only while that register is still renamed to the broadcast tag, and it then clears the pending state. A later rename of the same register keeps its tag, and the architectural value comes from the youngest writer.
- R9: If an operation is accepted in the cycle in which its source's producer broadcasts, the station takes the bus data at once, and it broadcasts EXEC_LAT edges after acceptance. If that operation also renames the broadcasting register, the register stays pending on the new tag while taking the broadcast value.
- R10: When several stations are ready in the same cycle, the one accepted earliest dispatches first, regardless of station number. A dispatch happens in every cycle in which some station is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation offered for issue |
| issue_ready_o | output | 1 | A station is free |
| issue_tag_o | output | TAG_W | Station the offered operation would take |
| issue_op_i | input | 2 | Operation code |
| issue_rd_i | input | REG_W | Destination register |
| issue_rs1_i | input | REG_W | First source register |
| issue_rs2_i | input | REG_W | Second source register |
| cdb_valid_o | output | 1 | Result bus carries a result |
| cdb_tag_o | output | TAG_W | Station tag of the result |
| cdb_data_o | output | DATA_W | Result value |
| rf_raddr_i | input | REG_W | Register to observe |
| rf_rdata_o | output | DATA_W | Architectural value of that register |
| rf_pending_o | output | 1 | A rename is pending on that register |

## Verification
Two pairs of functions can land in the same cycle. The first pair is issue and broadcast. The bench issues a producer, waits exactly EXEC_LAT idle cycles, confirms that the producer's tag is on the bus, and then offers a consumer that reads and rewrites the producer's destination. It judges the result by the register still being pending with the broadcast value already written, and by the consumer appearing on the bus exactly EXEC_LAT edges later. The second pair is two wakeups from one broadcast. A dependency chain is arranged so that an older station with a higher number and a younger station with a lower number are woken together, and the logged order of broadcasts must follow the order of issue.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;
endpackage

// File: rtl/rs_rat.sv
module rs_rat #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 2,
  parameter int unsigned REG_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  output logic [DATA_W-1:0] a_val_o,
  output logic              a_pend_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] b_val_o,
  output logic              b_pend_o,
  output logic [TAG_W-1:0]  b_tag_o,
  input  logic              alloc_i,
  input  logic [REG_W-1:0]  alloc_rd_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic [REG_W-1:0]  obs_addr_i,
  output logic [DATA_W-1:0] obs_data_o,
  output logic              obs_pend_o
);

  logic [DATA_W-1:0] rf_q   [NUM_REGS];
  logic [TAG_W-1:0]  tag_q  [NUM_REGS];
  logic [NUM_REGS-1:0] pend_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    logic ren;
    assign hit = cdb_valid_i && pend_q[r] && (tag_q[r] == cdb_tag_i);
    assign ren = alloc_i && (alloc_rd_i == REG_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rf_q[r]   <= DATA_W'(17 * r + 5);
        tag_q[r]  <= '0;
        pend_q[r] <= 1'b0;
      end else begin
        if (hit) rf_q[r] <= cdb_data_i;
        // rename wins over the clear of an older producer
        if (ren) begin
          pend_q[r] <= 1'b1;
          tag_q[r]  <= alloc_tag_i;
        end else if (hit) begin
          pend_q[r] <= 1'b0;
        end
      end
    end
  end

  assign a_val_o    = rf_q[src_a_i];
  assign a_pend_o   = pend_q[src_a_i];
  assign a_tag_o    = tag_q[src_a_i];
  assign b_val_o    = rf_q[src_b_i];
  assign b_pend_o   = pend_q[src_b_i];
  assign b_tag_o    = tag_q[src_b_i];
  assign obs_data_o = rf_q[obs_addr_i];
  assign obs_pend_o = pend_q[obs_addr_i];

endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  rs_pkg::op_e       alloc_op_i,
  input  logic              alloc_a_rdy_i,
  input  logic [TAG_W-1:0]  alloc_a_tag_i,
  input  logic [DATA_W-1:0] alloc_a_val_i,
  input  logic              alloc_b_rdy_i,
  input  logic [TAG_W-1:0]  alloc_b_tag_i,
  input  logic [DATA_W-1:0] alloc_b_val_i,
  input  logic              disp_i,
  input  logic              free_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              busy_o,
  output logic              req_o,
  output logic              a_rdy_o,
  output logic              b_rdy_o,
  output rs_pkg::op_e       op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);

  logic              busy_q, sent_q;
  logic              a_rdy_q, b_rdy_q;
  logic [TAG_W-1:0]  a_tag_q, b_tag_q;
  logic [DATA_W-1:0] a_q, b_q;
  rs_pkg::op_e       op_q;
  logic              a_wake, b_wake;

  assign a_wake = busy_q && !a_rdy_q && cdb_valid_i && (cdb_tag_i == a_tag_q);
  assign b_wake = busy_q && !b_rdy_q && cdb_valid_i && (cdb_tag_i == b_tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sent_q  <= 1'b0;
      a_rdy_q <= 1'b0;
      b_rdy_q <= 1'b0;
      a_tag_q <= '0;
      b_tag_q <= '0;
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= rs_pkg::OP_ADD;
    end else if (alloc_i) begin
      busy_q  <= 1'b1;
      sent_q  <= 1'b0;
      op_q    <= alloc_op_i;
      a_rdy_q <= alloc_a_rdy_i;
      a_tag_q <= alloc_a_tag_i;
      a_q     <= alloc_a_val_i;
      b_rdy_q <= alloc_b_rdy_i;
      b_tag_q <= alloc_b_tag_i;
      b_q     <= alloc_b_val_i;
    end else begin
      if (free_i) busy_q <= 1'b0;
      if (disp_i) sent_q <= 1'b1;
      if (a_wake) begin
        a_q     <= cdb_data_i;
        a_rdy_q <= 1'b1;
      end
      if (b_wake) begin
        b_q     <= cdb_data_i;
        b_rdy_q <= 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign req_o   = busy_q && !sent_q && a_rdy_q && b_rdy_q;
  assign a_rdy_o = a_rdy_q;
  assign b_rdy_o = b_rdy_q;
  assign op_o    = op_q;
  assign a_o     = a_q;
  assign b_o     = b_q;

endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int unsigned NUM_RS = 3,
  parameter int unsigned TAG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_idx_i,
  input  logic [NUM_RS-1:0] req_i,
  output logic              gnt_valid_o,
  output logic [TAG_W-1:0]  gnt_idx_o
);

  // older_q[i][j]: station i was allocated before station j
  logic [NUM_RS-1:0] older_q [NUM_RS];
  logic [NUM_RS-1:0] gnt_vec;
  logic [NUM_RS-1:0] blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_RS; i++) older_q[i] <= '0;
    end else if (alloc_i) begin
      for (int j = 0; j < NUM_RS; j++) begin
        older_q[alloc_idx_i][j] <= 1'b0;
        if (TAG_W'(j) != alloc_idx_i) older_q[j][alloc_idx_i] <= 1'b1;
      end
    end
  end

  always_comb begin
    blocked = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      for (int j = 0; j < NUM_RS; j++) begin
        if (req_i[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
    end
    gnt_vec = req_i & ~blocked;
  end

  always_comb begin
    gnt_idx_o = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (gnt_vec[i]) gnt_idx_o = TAG_W'(i);
    end
  end

  assign gnt_valid_o = |gnt_vec;

endmodule

// File: rtl/rs_exec.sv
module rs_exec #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  rs_pkg::op_e       in_op_i,
  input  logic [DATA_W-1:0] in_a_i,
  input  logic [DATA_W-1:0] in_b_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  output logic              out_valid_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [DATA_W-1:0] out_data_o
);

  logic [DATA_W-1:0] res;
  logic [LAT-1:0]    v_q;
  logic [TAG_W-1:0]  tag_q [LAT];
  logic [DATA_W-1:0] dat_q [LAT];

  always_comb begin
    unique case (in_op_i)
      rs_pkg::OP_ADD: res = in_a_i + in_b_i;
      rs_pkg::OP_SUB: res = in_a_i - in_b_i;
      rs_pkg::OP_AND: res = in_a_i & in_b_i;
      default:        res = in_a_i ^ in_b_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
    end else begin
      v_q[0] <= in_valid_i;
      for (int s = 1; s < LAT; s++) v_q[s] <= v_q[s-1];
    end
  end

  always_ff @(posedge clk_i) begin
    tag_q[0] <= in_tag_i;
    dat_q[0] <= res;
    for (int s = 1; s < LAT; s++) begin
      tag_q[s] <= tag_q[s-1];
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign out_valid_o = v_q[LAT-1];
  assign out_tag_o   = tag_q[LAT-1];
  assign out_data_o  = dat_q[LAT-1];

endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int unsigned NUM_RS   = 3,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned EXEC_LAT = 2,
  parameter int unsigned TAG_W    = (NUM_RS > 1) ? $clog2(NUM_RS) : 1,
  parameter int unsigned REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  input  logic [1:0]        issue_op_i,
  input  logic [REG_W-1:0]  issue_rd_i,
  input  logic [REG_W-1:0]  issue_rs1_i,
  input  logic [REG_W-1:0]  issue_rs2_i,
  output logic              cdb_valid_o,
  output logic [TAG_W-1:0]  cdb_tag_o,
  output logic [DATA_W-1:0] cdb_data_o,
  input  logic [REG_W-1:0]  rf_raddr_i,
  output logic [DATA_W-1:0] rf_rdata_o,
  output logic              rf_pending_o
);

  logic [NUM_RS-1:0] busy_vec, req_vec, rdy_a_vec, rdy_b_vec;
  logic              accept;
  logic [TAG_W-1:0]  alloc_idx;

  logic [DATA_W-1:0] ra_val, rb_val;
  logic              ra_pend, rb_pend;
  logic [TAG_W-1:0]  ra_tag, rb_tag;
  logic              a_rdy, b_rdy;
  logic [DATA_W-1:0] a_val, b_val;
  logic              a_hit, b_hit;

  logic              gnt_valid;
  logic [TAG_W-1:0]  gnt_idx;

  logic              bus_v;
  logic [TAG_W-1:0]  bus_tag;
  logic [DATA_W-1:0] bus_data;

  rs_pkg::op_e       ent_op [NUM_RS];
  logic [DATA_W-1:0] ent_a  [NUM_RS];
  logic [DATA_W-1:0] ent_b  [NUM_RS];

  always_comb begin
    alloc_idx = '0;
    for (int i = NUM_RS - 1; i >= 0; i--) begin
      if (!busy_vec[i]) alloc_idx = TAG_W'(i);
    end
  end

  assign issue_ready_o = ~&busy_vec;
  assign issue_tag_o   = alloc_idx;
  assign accept        = issue_valid_i && issue_ready_o;

  rs_rat #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W),
    .REG_W    (REG_W)
  ) i_rat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_a_i     (issue_rs1_i),
    .src_b_i     (issue_rs2_i),
    .a_val_o     (ra_val),
    .a_pend_o    (ra_pend),
    .a_tag_o     (ra_tag),
    .b_val_o     (rb_val),
    .b_pend_o    (rb_pend),
    .b_tag_o     (rb_tag),
    .alloc_i     (accept),
    .alloc_rd_i  (issue_rd_i),
    .alloc_tag_i (alloc_idx),
    .cdb_valid_i (bus_v),
    .cdb_tag_i   (bus_tag),
    .cdb_data_i  (bus_data),
    .obs_addr_i  (rf_raddr_i),
    .obs_data_o  (rf_rdata_o),
    .obs_pend_o  (rf_pending_o)
  );

  // a source whose producer broadcasts this cycle is taken from the bus
  assign a_hit = ra_pend && bus_v && (bus_tag == ra_tag);
  assign b_hit = rb_pend && bus_v && (bus_tag == rb_tag);
  assign a_rdy = !ra_pend || a_hit;
  assign b_rdy = !rb_pend || b_hit;
  assign a_val = a_hit ? bus_data : ra_val;
  assign b_val = b_hit ? bus_data : rb_val;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_ent
    logic sel, disp, fre;
    assign sel  = accept && (alloc_idx == TAG_W'(i));
    assign disp = gnt_valid && (gnt_idx == TAG_W'(i));
    assign fre  = bus_v && (bus_tag == TAG_W'(i));

    rs_entry #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W)
    ) i_entry (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .alloc_i       (sel),
      .alloc_op_i    (rs_pkg::op_e'(issue_op_i)),
      .alloc_a_rdy_i (a_rdy),
      .alloc_a_tag_i (ra_tag),
      .alloc_a_val_i (a_val),
      .alloc_b_rdy_i (b_rdy),
      .alloc_b_tag_i (rb_tag),
      .alloc_b_val_i (b_val),
      .disp_i        (disp),
      .free_i        (fre),
      .cdb_valid_i   (bus_v),
      .cdb_tag_i     (bus_tag),
      .cdb_data_i    (bus_data),
      .busy_o        (busy_vec[i]),
      .req_o         (req_vec[i]),
      .a_rdy_o       (rdy_a_vec[i]),
      .b_rdy_o       (rdy_b_vec[i]),
      .op_o          (ent_op[i]),
      .a_o           (ent_a[i]),
      .b_o           (ent_b[i])
    );
  end

  rs_select #(
    .NUM_RS (NUM_RS),
    .TAG_W  (TAG_W)
  ) i_select (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (accept),
    .alloc_idx_i (alloc_idx),
    .req_i       (req_vec),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  rs_exec #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .LAT    (EXEC_LAT)
  ) i_exec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (gnt_valid),
    .in_op_i     (ent_op[gnt_idx]),
    .in_a_i      (ent_a[gnt_idx]),
    .in_b_i      (ent_b[gnt_idx]),
    .in_tag_i    (gnt_idx),
    .out_valid_o (bus_v),
    .out_tag_o   (bus_tag),
    .out_data_o  (bus_data)
  );

  assign cdb_valid_o = bus_v;
  assign cdb_tag_o   = bus_tag;
  assign cdb_data_o  = bus_data;

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int unsigned NUM_RS = 3,
  parameter int unsigned TAG_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_valid_i,
  input logic              issue_ready_i,
  input logic [TAG_W-1:0]  issue_tag_i,
  input logic              cdb_valid_i,
  input logic [TAG_W-1:0]  cdb_tag_i,
  input logic [NUM_RS-1:0] busy_i,
  input logic [NUM_RS-1:0] req_i,
  input logic [NUM_RS-1:0] rdy_a_i,
  input logic [NUM_RS-1:0] rdy_b_i,
  input logic              gnt_valid_i,
  input logic [TAG_W-1:0]  gnt_idx_i
);

  p_alloc_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_ready_i) |=> busy_i[$past(issue_tag_i)]);

  p_bcast_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i |-> busy_i[cdb_tag_i]);

  p_free_after_bcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i |=> !busy_i[$past(cdb_tag_i)]);

  p_disp_operands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_i |-> (rdy_a_i[gnt_idx_i] && rdy_b_i[gnt_idx_i]));

  p_gnt_requested_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_i |-> req_i[gnt_idx_i]);

  p_no_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> gnt_valid_i);

endmodule

bind rs_pool rs_pool_chk #(
  .NUM_RS (NUM_RS),
  .TAG_W  (TAG_W)
) i_rs_pool_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .issue_ready_i (issue_ready_o),
  .issue_tag_i   (issue_tag_o),
  .cdb_valid_i   (cdb_valid_o),
  .cdb_tag_i     (cdb_tag_o),
  .busy_i        (busy_vec),
  .req_i         (req_vec),
  .rdy_a_i       (rdy_a_vec),
  .rdy_b_i       (rdy_b_vec),
  .gnt_valid_i   (gnt_valid),
  .gnt_idx_i     (gnt_idx)
);

// File: tb/test_rs_pool.sv
module test_rs_pool;
  localparam int NRS  = 3;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int LAT  = 2;
  localparam int TW   = 2;
  localparam int RW   = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid_i = 1'b0;
  logic          issue_ready_o;
  logic [TW-1:0] issue_tag_o;
  logic [1:0]    issue_op_i = '0;
  logic [RW-1:0] issue_rd_i = '0, issue_rs1_i = '0, issue_rs2_i = '0;
  logic          cdb_valid_o;
  logic [TW-1:0] cdb_tag_o;
  logic [DW-1:0] cdb_data_o;
  logic [RW-1:0] rf_raddr_i = '0;
  logic [DW-1:0] rf_rdata_o;
  logic          rf_pending_o;

  always #10 clk = ~clk;

  rs_pool #(.NUM_RS(NRS), .NUM_REGS(NREG), .DATA_W(DW), .EXEC_LAT(LAT)) i_rs_pool (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid_i), .issue_ready_o(issue_ready_o), .issue_tag_o(issue_tag_o),
    .issue_op_i(issue_op_i), .issue_rd_i(issue_rd_i),
    .issue_rs1_i(issue_rs1_i), .issue_rs2_i(issue_rs2_i),
    .cdb_valid_o(cdb_valid_o), .cdb_tag_o(cdb_tag_o), .cdb_data_o(cdb_data_o),
    .rf_raddr_i(rf_raddr_i), .rf_rdata_o(rf_rdata_o), .rf_pending_o(rf_pending_o)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [DW-1:0] mrf [NREG];
  logic [DW-1:0] exp_d [4];
  int            exp_seq [4];
  int            exp_cyc [4];
  bit            exp_live [4];
  int            seq_n = 0;
  int            blog [2048];
  int            bcnt = 0;
  int            last_tag;
  int            last_seq;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] alu(input logic [1:0] op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  // result bus monitor: R5/R3 data, R6 minimum latency, R7 single broadcast
  always @(negedge clk) begin
    if (rst_ni && cdb_valid_o) begin
      int t;
      t = int'(cdb_tag_o);
      if (!exp_live[t]) begin
        chk(1'b0, "R7", "broadcast with no live op on tag", t, -1);
      end else begin
        chk(cdb_data_o == exp_d[t], "R5", "broadcast data", cdb_data_o, exp_d[t]);
        chk(cyc - exp_cyc[t] >= LAT, "R6", "cycles from accept to broadcast",
            cyc - exp_cyc[t], LAT);
        exp_live[t] = 1'b0;
        blog[bcnt] = exp_seq[t];
        bcnt++;
      end
    end
  end

  task automatic idle(input int n);
    issue_valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_issue(input int op, input int rd, input int rs1, input int rs2);
    logic [DW-1:0] res;
    int t;
    while (!issue_ready_o) begin
      issue_valid_i = 1'b0;
      @(negedge clk);
    end
    issue_valid_i = 1'b1;
    issue_op_i    = 2'(op);
    issue_rd_i    = RW'(rd);
    issue_rs1_i   = RW'(rs1);
    issue_rs2_i   = RW'(rs2);
    t   = int'(issue_tag_o);
    res = alu(2'(op), mrf[rs1], mrf[rs2]);
    mrf[rd] = res;
    exp_d[t]    = res;
    exp_seq[t]  = seq_n;
    exp_cyc[t]  = cyc + 1;
    exp_live[t] = 1'b1;
    last_tag = t;
    last_seq = seq_n;
    seq_n++;
    @(negedge clk);
  endtask

  task automatic rd_reg(input int r, output logic [DW-1:0] d, output logic p);
    rf_raddr_i = RW'(r);
    #1;
    d = rf_rdata_o;
    p = rf_pending_o;
  endtask

  task automatic check_all_regs(input string req);
    for (int r = 0; r < NREG; r++) begin
      logic [DW-1:0] d;
      logic p;
      rd_reg(r, d, p);
      chk(d == mrf[r], req, "register value after drain", d, mrf[r]);
      chk(p == 1'b0, req, "pending after drain", p, 0);
    end
    for (int t = 0; t < 4; t++)
      chk(exp_live[t] == 1'b0, "R7", "operation never broadcast", t, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic p;
    int sa, sb, ta, tb, b0, tp, tc;
    logic [DW-1:0] pres;

    for (int r = 0; r < NREG; r++) mrf[r] = DW'(17 * r + 5);
    for (int t = 0; t < 4; t++) exp_live[t] = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(issue_ready_o == 1'b1, "R1", "ready after reset", issue_ready_o, 1);
    chk(cdb_valid_o == 1'b0, "R1", "bus idle after reset", cdb_valid_o, 0);
    for (int r = 0; r < NREG; r++) begin
      rd_reg(r, d, p);
      chk(d == DW'(17 * r + 5), "R1", "reset register value", d, 17 * r + 5);
      chk(p == 1'b0, "R1", "reset pending", p, 0);
    end
    @(negedge clk);

    // R6/R2/R4 isolated op latency
    do_issue(0, 1, 2, 3);
    chk(last_tag == 0, "R2", "lowest free station", last_tag, 0);
    rd_reg(1, d, p);
    chk(p == 1'b1, "R4", "destination pending after issue", p, 1);
    idle(LAT - 1);
    chk(cdb_valid_o == 1'b0, "R6", "no early broadcast", cdb_valid_o, 0);
    idle(1);
    chk(cdb_valid_o == 1'b1 && cdb_tag_o == 0, "R6", "broadcast after EXEC_LAT edges",
        cdb_valid_o, 1);
    idle(1);
    chk(issue_ready_o == 1'b1, "R7", "station freed", issue_ready_o, 1);
    rd_reg(1, d, p);
    chk(d == mrf[1] && p == 1'b0, "R8", "register written by own tag", d, mrf[1]);
    idle(10);

    // R2 fill and stall, R5 dependency chain
    do_issue(0, 1, 1, 2);
    do_issue(1, 4, 1, 3);
    do_issue(3, 5, 4, 1);
    chk(issue_ready_o == 1'b0, "R2", "ready low when all stations busy", issue_ready_o, 0);
    do_issue(2, 6, 5, 2);
    chk(last_tag == 0, "R2", "stalled op takes freed station 0", last_tag, 0);
    idle(30);
    check_all_regs("R5");

    // R10 older higher-numbered station dispatches before younger lower one
    b0 = bcnt;
    do_issue(0, 1, 2, 3);
    do_issue(1, 2, 1, 4);
    do_issue(3, 3, 2, 5);
    ta = last_tag; sa = last_seq;
    do_issue(2, 6, 2, 7);
    tb = last_tag; sb = last_seq;
    chk(ta == 2, "R10", "older waiter station", ta, 2);
    chk(tb == 0, "R10", "younger waiter station", tb, 0);
    idle(30);
    chk(blog[b0 + 2] == sa, "R10", "oldest ready dispatched first", blog[b0 + 2], sa);
    chk(blog[b0 + 3] == sb, "R10", "younger ready dispatched second", blog[b0 + 3], sb);
    check_all_regs("R10");

    // R9 issue in the broadcast cycle of its producer, renaming the same register
    do_issue(0, 1, 2, 3);
    tp = last_tag;
    pres = exp_d[tp];
    idle(LAT);
    chk(cdb_valid_o == 1'b1 && int'(cdb_tag_o) == tp, "R9", "producer on bus at issue",
        cdb_valid_o, 1);
    do_issue(0, 1, 1, 4);
    tc = last_tag;
    rd_reg(1, d, p);
    chk(p == 1'b1, "R9", "rename kept over broadcast clear", p, 1);
    chk(d == pres, "R8", "broadcast value written under rename", d, pres);
    idle(LAT);
    chk(cdb_valid_o == 1'b1 && int'(cdb_tag_o) == tc, "R9", "consumer took bus value",
        cdb_valid_o, 1);
    idle(20);
    check_all_regs("R9");

    // R8 older writer finishing after a younger rename
    do_issue(0, 1, 4, 5);
    do_issue(0, 3, 1, 2);
    do_issue(3, 3, 4, 6);
    idle(30);
    rd_reg(3, d, p);
    chk(d == mrf[3], "R8", "youngest writer kept", d, mrf[3]);
    check_all_regs("R8");

    // R3 operation sweep on every op code and register pair
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < NREG; a++) begin
        do_issue(op, (a + op + 1) % NREG, a, (a * 3 + op) % NREG);
      end
    end
    idle(30);
    check_all_regs("R3");

    // R5/R8 random stream
    for (int n = 0; n < 600; n++) begin
      do_issue(int'($urandom_range(0, 3)), int'($urandom_range(0, NREG - 1)),
               int'($urandom_range(0, NREG - 1)), int'($urandom_range(0, NREG - 1)));
      if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 4)));
    end
    idle(40);
    check_all_regs("R5");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule